// File: doc/BRIEF.md
# Multi-stream pseudorandom bit source

The block produces twelve binary pseudorandom streams that look mutually uncorrelated, yet it holds only two maximal-length linear feedback generators. Six streams come from each generator. Every stream is the base sequence of its generator delayed by its own number of clock periods. Each delay is a large fraction of the period, and all the delays are distinct primes, so no two share a factor. The block holds no history of the sequence. Each delayed copy is the XOR of a fixed set of generator state bits. That set is worked out during elaboration from the feedback polynomial and the delay. A constant delay of hundreds of millions of cycles therefore costs only one parity tree per stream.

Downstream logic, such as weighted-sum filters that shape and combine the streams, takes one bit per stream on each enabled clock. A synchronous restart loads both generators with fixed non-zero seeds. A noise run can then be repeated exactly, in step with a data pattern that is restarted at the same moment. When the clock enable is low, all state and outputs freeze, and a later resume continues from where the run stopped.

Top module: `mspr_multistream`

## Requirements
- R1: Generator A has 31 state bits and generator B has 29. Each one multiplies its state polynomial by x modulo its feedback polynomial on each step: x^31+x^3+1 for A and x^29+x^2+1 for B. So S(t+1) = x·S(t) mod p, state bit i holds the coefficient of x^i, and base(t) is the top state bit of S(t). The state is never zero.
- R2: Output bit k, for k = 0..5, carries generator A's base sequence delayed by D_A[k]. Output bit 6+j, for j = 0..5, carries generator B's base sequence delayed by D_B[j]. The delay is taken modulo the period 2^n−1, so stream(t) = base(t − D). The defaults are D_A = {1000000007, 1000000009, 998244353, 999999937, 1000000021, 1000000033} and D_B = {469762049, 452984833, 433494437, 377487361, 167772161, 104857601}, all distinct primes.
- R3: A clock edge with `restart` high loads S(0) = 31'h12345678 into A and 29'h0ACE5EED into B. After that edge the outputs show the t = 0 values of every stream.
- R4: An edge with `en` low and `restart` low changes neither the generator state nor any output bit.
- R5: `restart` takes effect whatever the level of `en`.
- R6: Each edge with `en` high and `restart` low advances every stream by exactly one sequence position. The new bits are visible right after that edge, and a resume after a freeze skips no position.
- R7: Two runs that start from a restart and see the same enable pattern produce identical output vectors, cycle for cycle.
- R8: Over 64 consecutive enabled cycles, no two streams are equal and no stream is the complement of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| restart | input | 1 | Synchronous, active-high; loads both seeds |
| en | input | 1 | Clock enable; low freezes all state |
| streams | output | 12 | Registered stream bits; [5:0] from generator A, [11:6] from generator B |

## Verification
Every output is a register loaded from the generators' next state. The bits for sequence position t therefore appear right after the edge that sampled `restart`, or a high `en`, moving the run to t. The bench drives inputs on the falling edge and compares the vector on the next falling edge, exactly one rising edge later. Its model advances a software state on each rising edge and multiplies it by x^(period − delay) to predict each stream's bit. Freeze checks compare against the vector held before the freeze. Repeat checks compare two recorded runs position by position.

// File: rtl/mspr_pkg.sv
package mspr_pkg;

  localparam int unsigned POLY_W = 32;

  function automatic logic [POLY_W-1:0] width_ones(input int n);
    logic [POLY_W-1:0] m;
    if (n >= POLY_W) m = '1;
    else m = (32'd1 << n) - 32'd1;
    return m;
  endfunction

  // Multiply a residue by x modulo the feedback polynomial (low terms in plow).
  function automatic logic [POLY_W-1:0] gf_times_x(input logic [POLY_W-1:0] a,
                                                   input int n,
                                                   input logic [POLY_W-1:0] plow);
    logic [POLY_W-1:0] r;
    r = (a << 1) & width_ones(n);
    if (a[n-1]) r = r ^ plow;
    return r;
  endfunction

  // Product of two residues, Horner over the bits of b.
  function automatic logic [POLY_W-1:0] gf_product(input logic [POLY_W-1:0] a,
                                                   input logic [POLY_W-1:0] b,
                                                   input int n,
                                                   input logic [POLY_W-1:0] plow);
    logic [POLY_W-1:0] r;
    r = '0;
    for (int i = POLY_W - 1; i >= 0; i--) begin
      r = gf_times_x(r, n, plow);
      if (b[i] && (i < n)) r = r ^ a;
    end
    return r;
  endfunction

  // x^e modulo the feedback polynomial, left-to-right square and multiply.
  function automatic logic [POLY_W-1:0] gf_x_power(input logic [POLY_W-1:0] e,
                                                   input int n,
                                                   input logic [POLY_W-1:0] plow);
    logic [POLY_W-1:0] r;
    r = 32'd1;
    for (int i = POLY_W - 1; i >= 0; i--) begin
      r = gf_product(r, r, n, plow);
      if (e[i]) r = gf_times_x(r, n, plow);
    end
    return r;
  endfunction

  // State-bit selection whose parity equals the top bit of x^e * S mod p.
  function automatic logic [POLY_W-1:0] advance_taps(input logic [POLY_W-1:0] e,
                                                     input int n,
                                                     input logic [POLY_W-1:0] plow);
    logic [POLY_W-1:0] q;
    logic [POLY_W-1:0] m;
    q = gf_x_power(e, n, plow);
    m = '0;
    for (int j = 0; j < n; j++) begin
      m[j] = q[n-1];
      q = gf_times_x(q, n, plow);
    end
    return m;
  endfunction

endpackage

// File: rtl/mspr_galois_gen.sv
module mspr_galois_gen #(
  parameter int unsigned   W    = 31,
  parameter logic [W-1:0]  PLOW = 'h9,
  parameter logic [W-1:0]  SEED = 'h1
) (
  input  logic         clk,
  input  logic         restart,
  input  logic         en,
  output logic [W-1:0] state_next
);

  logic [W-1:0] state_q;
  logic [W-1:0] stepped;

  always_comb begin
    stepped = {state_q[W-2:0], 1'b0};
    if (state_q[W-1]) stepped = stepped ^ PLOW;
  end

  always_comb begin
    if (restart)  state_next = SEED;
    else if (en)  state_next = stepped;
    else          state_next = state_q;
  end

  always_ff @(posedge clk) begin
    state_q <= state_next;
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (restart)
    state_q != '0);  // R1

  AST_TOP_FEEDS_BOTTOM: assert property (@(posedge clk) disable iff (restart)
    ($past(en) && !$past(restart)) |-> (state_q[0] == $past(state_q[W-1])));  // R1

  AST_SEED_LOADED: assert property (@(posedge clk) disable iff (restart)
    $past(restart) |-> (state_q == SEED));  // R3

  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (restart)
    (!$past(en) && !$past(restart)) |-> $stable(state_q));  // R4

endmodule

// File: rtl/mspr_tap_bank.sv
module mspr_tap_bank #(
  parameter int unsigned             W      = 31,
  parameter logic [W-1:0]            PLOW   = 'h9,
  parameter int unsigned             NS     = 6,
  parameter logic [NS-1:0][31:0]     DELAYS = '0
) (
  input  logic          clk,
  input  logic          restart,
  input  logic          en,
  input  logic [W-1:0]  state_next,
  output logic [NS-1:0] bits_q
);

  localparam logic [31:0] PERIOD = (32'd1 << W) - 32'd1;

  for (genvar k = 0; k < NS; k++) begin : g_tap
    localparam logic [31:0] ADVANCE = PERIOD - DELAYS[k];
    localparam logic [31:0] TAPS32  =
      mspr_pkg::advance_taps(ADVANCE, W, 32'(PLOW));
    localparam logic [W-1:0] TAPS = TAPS32[W-1:0];

    always_ff @(posedge clk) begin
      if (restart || en) bits_q[k] <= ^(state_next & TAPS);
    end
  end

  AST_BITS_FROZEN: assert property (@(posedge clk) disable iff (restart)
    (!$past(en) && !$past(restart)) |-> $stable(bits_q));  // R4

endmodule

// File: rtl/mspr_multistream.sv
module mspr_multistream #(
  parameter int unsigned              A_W      = 31,
  parameter logic [A_W-1:0]           A_PLOW   = 31'h9,
  parameter logic [A_W-1:0]           A_SEED   = 31'h12345678,
  parameter int unsigned              A_NS     = 6,
  parameter logic [A_NS-1:0][31:0]    A_DELAYS = {32'd1000000033, 32'd1000000021,
                                                  32'd999999937,  32'd998244353,
                                                  32'd1000000009, 32'd1000000007},
  parameter int unsigned              B_W      = 29,
  parameter logic [B_W-1:0]           B_PLOW   = 29'h5,
  parameter logic [B_W-1:0]           B_SEED   = 29'h0ACE5EED,
  parameter int unsigned              B_NS     = 6,
  parameter logic [B_NS-1:0][31:0]    B_DELAYS = {32'd104857601, 32'd167772161,
                                                  32'd377487361, 32'd433494437,
                                                  32'd452984833, 32'd469762049},
  localparam int unsigned             NSTR     = A_NS + B_NS
) (
  input  logic            clk,
  input  logic            restart,
  input  logic            en,
  output logic [NSTR-1:0] streams
);

  logic [A_W-1:0]  a_next;
  logic [B_W-1:0]  b_next;
  logic [A_NS-1:0] a_bits;
  logic [B_NS-1:0] b_bits;

  mspr_galois_gen #(.W(A_W), .PLOW(A_PLOW), .SEED(A_SEED)) u_gen_a (
    .clk(clk), .restart(restart), .en(en), .state_next(a_next)
  );

  mspr_galois_gen #(.W(B_W), .PLOW(B_PLOW), .SEED(B_SEED)) u_gen_b (
    .clk(clk), .restart(restart), .en(en), .state_next(b_next)
  );

  mspr_tap_bank #(.W(A_W), .PLOW(A_PLOW), .NS(A_NS), .DELAYS(A_DELAYS)) u_bank_a (
    .clk(clk), .restart(restart), .en(en), .state_next(a_next), .bits_q(a_bits)
  );

  mspr_tap_bank #(.W(B_W), .PLOW(B_PLOW), .NS(B_NS), .DELAYS(B_DELAYS)) u_bank_b (
    .clk(clk), .restart(restart), .en(en), .state_next(b_next), .bits_q(b_bits)
  );

  assign streams = {b_bits, a_bits};

endmodule

// File: tb/mspr_multistream_bench.sv
`timescale 1ns/1ps
module mspr_multistream_bench;

  logic        clk = 1'b0;
  logic        restart = 1'b1;
  logic        en = 1'b0;
  logic [11:0] streams;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] PA = 32'h9;
  localparam logic [31:0] PB = 32'h5;
  localparam logic [31:0] LA = 32'h7FFFFFFF;
  localparam logic [31:0] LB = 32'h1FFFFFFF;
  localparam logic [31:0] SEED_A = 32'h12345678;
  localparam logic [31:0] SEED_B = 32'h0ACE5EED;

  logic [31:0] da [6] = '{32'd1000000007, 32'd1000000009, 32'd998244353,
                          32'd999999937, 32'd1000000021, 32'd1000000033};
  logic [31:0] db [6] = '{32'd469762049, 32'd452984833, 32'd433494437,
                          32'd377487361, 32'd167772161, 32'd104857601};
  logic [31:0] qa [6];
  logic [31:0] qb [6];
  logic [31:0] sa, sb;
  logic [11:0] rec [200];

  always #2 clk = ~clk;

  mspr_multistream u_mspr_multistream (
    .clk(clk), .restart(restart), .en(en), .streams(streams)
  );

  function automatic logic [31:0] m_shift(logic [31:0] a, int n, logic [31:0] pl);
    logic [31:0] r;
    r = (a << 1) & ((32'd1 << n) - 32'd1);
    if (a[n-1]) r = r ^ pl;
    return r;
  endfunction

  // Shift-and-add product, low bits of b first.
  function automatic logic [31:0] m_mul(logic [31:0] a, logic [31:0] b, int n,
                                        logic [31:0] pl);
    logic [31:0] r, t;
    r = '0;
    t = a;
    for (int i = 0; i < n; i++) begin
      if (b[i]) r = r ^ t;
      t = m_shift(t, n, pl);
    end
    return r;
  endfunction

  // x^e mod p, right-to-left binary exponent.
  function automatic logic [31:0] m_pow(logic [31:0] e, int n, logic [31:0] pl);
    logic [31:0] r, base;
    r = 32'd1;
    base = 32'd2;
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = m_mul(r, base, n, pl);
      base = m_mul(base, base, n, pl);
    end
    return r;
  endfunction

  // Bits of every stream at the current model positions (stream(t) = base(t - D)).
  function automatic logic [11:0] expect_vec();
    logic [11:0] v;
    logic [31:0] t;
    for (int k = 0; k < 6; k++) begin
      t = m_mul(qa[k], sa, 31, PA);
      v[k] = t[30];
      t = m_mul(qb[k], sb, 29, PB);
      v[6+k] = t[28];
    end
    return v;
  endfunction

  task automatic check_vec(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge act, compare at the next falling edge.
  task automatic cyc(logic e, logic r, string req);
    en = e;
    restart = r;
    @(posedge clk);
    if (r) begin
      sa = SEED_A;
      sb = SEED_B;
    end else if (e) begin
      sa = m_shift(sa, 31, PA);
      sb = m_shift(sb, 29, PB);
    end
    @(negedge clk);
    check_vec(req, streams, expect_vec());
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] hold;
    logic [63:0] col [12];
    void'($urandom(32'd20240611));
    for (int k = 0; k < 6; k++) begin
      qa[k] = m_pow(LA - da[k], 31, PA);
      qb[k] = m_pow(LB - db[k], 29, PB);
    end
    sa = SEED_A;
    sb = SEED_B;

    // Reset state: t = 0 of every stream (R3)
    cyc(1'b0, 1'b1, "R3 reset state");
    cyc(1'b0, 1'b1, "R3 restart held");
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, "R1 R2 R6 run");

    // Freeze (R4), then resume without skipping (R6)
    hold = streams;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b0, "R4 model");
      check_vec("R4 frozen output", streams, hold);
    end
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, "R6 resume");

    // Restart while enable is low (R5)
    cyc(1'b0, 1'b1, "R5 restart with en low");
    cyc(1'b1, 1'b0, "R5 step after restart");
    cyc(1'b1, 1'b1, "R5 restart with en high");

    // Repeatability (R7)
    for (int i = 0; i < 200; i++) begin
      cyc(1'b1, 1'b0, "R2 R7 first run");
      rec[i] = streams;
    end
    cyc(1'b0, 1'b1, "R3 R7 second restart");
    for (int i = 0; i < 200; i++) begin
      cyc(1'b1, 1'b0, "R2 R7 second run");
      check_vec("R7 repeat", streams, rec[i]);
    end

    // Distinctness over 64 enabled cycles (R8)
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, 1'b0, "R2 R8 window");
      for (int k = 0; k < 12; k++) col[k][i] = streams[k];
    end
    for (int k = 0; k < 12; k++) begin
      for (int j = k + 1; j < 12; j++) begin
        checks++;
        if (col[k] == col[j] || col[k] == ~col[j]) begin
          errors++;
          $display("FAIL R8 streams %0d,%0d actual=%h,%h expected=distinct",
                   k, j, col[k], col[j]);
        end
      end
    end

    // Random enable and occasional restart (R1 R2 R4 R5 R6)
    for (int i = 0; i < 3000; i++) begin
      logic e, r;
      e = ($urandom % 4) != 0;
      r = ($urandom % 500) == 0;
      cyc(e, r, "R1 R2 R6 random");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule